// File: doc/BRIEF.md
# I/O Port Breakpoint Trap Unit

This block watches port-mapped I/O accesses and raises a debug trap when one touches a window guarded by a debug slot. Four slots each hold a port base address. A 32-bit debug control word gives every slot two enable bits, a 2-bit kind field and a 2-bit window-length field. Only slots whose kind is I/O and that have at least one enable bit set are armed.

An access arrives as a port number, a size in bytes and the address of the instruction after the port instruction. The unit tests that byte range against every armed slot window. If any window overlaps, the next cycle shows a write of the status word: its low four bits are replaced by the per-slot hit mask and its upper bits are kept. In the same cycle the unit loads the instruction pointer with the next-instruction address and requests a debug exception on vector 1. The trap is therefore taken after the access has completed. The unit also drives a registered flag that stays high while any slot is armed, so the pipeline knows when port accesses must be routed through this check.

The access interface is a valid/ready pair. The unit applies no back-pressure: `acc_ready` is low while reset is asserted and high from the first clock edge after reset, and an access is taken in every cycle where `acc_valid` and `acc_ready` are both high. The producer may hold `acc_valid` high on consecutive cycles. Each cycle with valid and ready high is a separate access.

Top module: `iobp_port_trap`

## Requirements
- R1: Slot i is armed only when its kind field `dbg_ctrl[16+4i +: 2]` equals 2'b10 (I/O) and at least one of its enable bits `dbg_ctrl[2i]` (local) or `dbg_ctrl[2i+1]` (global) is 1. Slots that are not armed never hit.
- R2: The window length comes from `dbg_ctrl[18+4i +: 2]`: code 0 gives 1 byte, 1 gives 2, 2 gives 8 and 3 gives 4.
- R3: Slot i hits when port+size-1 >= base_i and port <= base_i+len_i-1. Both sums are evaluated one bit wider than the port address, so no sum wraps around.
- R4: Hits are collected into a 4-bit mask with bit i for slot i. Several slots may hit on the same access.
- R5: On an access with any hit, the next cycle has `status_we`=1 and `status_out` = {status_in[31:4], mask}.
- R6: On an access with any hit, the next cycle has `ip_we`=1 with `ip_out` equal to the access's `acc_next_ip`, and `dbg_req`=1 with `dbg_vector`=1.
- R7: An access with no hit, or a cycle with no access, leaves `status_we`, `ip_we` and `dbg_req` at 0 and `status_out` and `ip_out` unchanged.
- R8: Results appear exactly one cycle after the access is taken, and the strobes last one cycle.
- R9: `io_check_en` is, one cycle later, 1 exactly when at least one slot was armed under R1.
- R10: Only access sizes 1, 2 and 4 are legal. An access of any other size produces no hit.
- R11: During reset all strobes, `io_check_en`, `acc_ready`, `status_out` and `ip_out` are 0, and `acc_ready` goes to 1 after the first clock edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_ctrl | input | 32 | Debug control word (enables, kinds, lengths) |
| slot_addr | input | 64 | Four 16-bit slot base addresses, slot i at [16i +: 16] |
| status_in | input | 32 | Current debug status word |
| acc_valid | input | 1 | Port access valid |
| acc_ready | output | 1 | Access accepted (high whenever out of reset) |
| acc_port | input | 16 | First port of the access |
| acc_size | input | 3 | Access size in bytes |
| acc_next_ip | input | 32 | Address of the following instruction |
| status_out | output | 32 | New status word |
| status_we | output | 1 | Status write strobe |
| ip_out | output | 32 | New instruction pointer |
| ip_we | output | 1 | Instruction pointer load strobe |
| dbg_req | output | 1 | Debug exception request |
| dbg_vector | output | 8 | Exception vector, constant 1 |
| io_check_en | output | 1 | At least one slot is armed |

## Verification
Two things register in the same cycle: the armed-slot flag, which follows the control word, and the trap outcome of an access. The bench changes `dbg_ctrl` in the same cycle as each access. In the next cycle it checks that the hit mask and `io_check_en` both follow the new control word. Accesses with and without a hit are interleaved, so the bench can also check that the status and pointer outputs hold their values when no hit occurs, and that every strobe drops one cycle after it rises.

// File: rtl/iobp_pkg.sv
package iobp_pkg;
  localparam int KIND_BASE   = 16;
  localparam int FIELD_STEP  = 4;
  localparam int LEN_OFS     = 2;
  localparam logic [1:0] KIND_IO = 2'b10;
  localparam int LEN_W       = 4;

  function automatic logic [LEN_W-1:0] decode_len(input logic [1:0] code);
    case (code)
      2'd0:    decode_len = 4'd1;
      2'd1:    decode_len = 4'd2;
      2'd2:    decode_len = 4'd8;
      default: decode_len = 4'd4;
    endcase
  endfunction

  function automatic logic size_legal(input logic [2:0] sz);
    size_legal = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/iobp_slot_decode.sv
module iobp_slot_decode
  import iobp_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter int IDX    = 0
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic              armed,
  output logic [LEN_W-1:0]  win_len
);
  localparam int EN_POS   = 2 * IDX;
  localparam int KIND_POS = KIND_BASE + FIELD_STEP * IDX;
  localparam int LEN_POS  = KIND_POS + LEN_OFS;

  logic       any_en;
  logic [1:0] kind;
  logic       unused_ctrl;

  assign any_en      = ctrl[EN_POS] | ctrl[EN_POS+1];
  assign kind        = ctrl[KIND_POS +: 2];
  assign armed       = any_en && (kind == KIND_IO);
  assign win_len     = decode_len(ctrl[LEN_POS +: 2]);
  assign unused_ctrl = ^ctrl;
endmodule

// File: rtl/iobp_range_match.sv
module iobp_range_match
  import iobp_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int SZ_W   = 3
) (
  input  logic              en,
  input  logic [PORT_W-1:0] slot_base,
  input  logic [LEN_W-1:0]  win_len,
  input  logic [PORT_W-1:0] acc_port,
  input  logic [SZ_W-1:0]   acc_size,
  output logic              hit
);
  localparam int XW = PORT_W + 1;

  logic [XW-1:0] base_x, port_x, size_x, len_x;
  logic [XW-1:0] acc_last, win_last;

  assign base_x   = {1'b0, slot_base};
  assign port_x   = {1'b0, acc_port};
  assign size_x   = XW'(acc_size);
  assign len_x    = XW'(win_len);
  assign acc_last = port_x + size_x - XW'(1);
  assign win_last = base_x + len_x - XW'(1);
  assign hit      = en && (acc_last >= base_x) && (port_x <= win_last);
endmodule

// File: rtl/iobp_port_trap.sv
module iobp_port_trap
  import iobp_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int PORT_W = 16,
  parameter int SZ_W   = 3,
  parameter int IP_W   = 32,
  parameter int STAT_W = 32,
  parameter int CTRL_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CTRL_W-1:0]       dbg_ctrl,
  input  logic [NSLOT*PORT_W-1:0] slot_addr,
  input  logic [STAT_W-1:0]       status_in,
  input  logic                    acc_valid,
  output logic                    acc_ready,
  input  logic [PORT_W-1:0]       acc_port,
  input  logic [SZ_W-1:0]         acc_size,
  input  logic [IP_W-1:0]         acc_next_ip,
  output logic [STAT_W-1:0]       status_out,
  output logic                    status_we,
  output logic [IP_W-1:0]         ip_out,
  output logic                    ip_we,
  output logic                    dbg_req,
  output logic [7:0]              dbg_vector,
  output logic                    io_check_en
);
  localparam logic [7:0] DB_VEC = 8'd1;

  logic [NSLOT-1:0]            armed;
  logic [NSLOT-1:0]            hit;
  logic [NSLOT-1:0][LEN_W-1:0] win_len;
  logic                        acc_take;
  logic                        size_ok;
  logic                        any_hit;
  logic                        unused_stat;

  assign acc_take    = acc_valid && acc_ready;
  assign size_ok     = size_legal(3'(acc_size));
  assign any_hit     = acc_take && (|hit);
  assign dbg_vector  = DB_VEC;
  assign unused_stat = ^status_in[NSLOT-1:0];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    iobp_slot_decode #(.CTRL_W(CTRL_W), .IDX(g)) u_dec (
      .ctrl    (dbg_ctrl),
      .armed   (armed[g]),
      .win_len (win_len[g])
    );
    iobp_range_match #(.PORT_W(PORT_W), .SZ_W(SZ_W)) u_match (
      .en        (armed[g] && size_ok),
      .slot_base (slot_addr[g*PORT_W +: PORT_W]),
      .win_len   (win_len[g]),
      .acc_port  (acc_port),
      .acc_size  (acc_size),
      .hit       (hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_ready   <= 1'b0;
      io_check_en <= 1'b0;
      status_out  <= '0;
      status_we   <= 1'b0;
      ip_out      <= '0;
      ip_we       <= 1'b0;
      dbg_req     <= 1'b0;
    end else begin
      acc_ready   <= 1'b1;
      io_check_en <= |armed;
      status_we   <= any_hit;
      ip_we       <= any_hit;
      dbg_req     <= any_hit;
      if (any_hit) begin
        status_out <= {status_in[STAT_W-1:NSLOT], hit};
        ip_out     <= acc_next_ip;
      end
    end
  end
endmodule

// File: rtl/iobp_port_trap_chk.sv
module iobp_port_trap_chk #(
  parameter int NSLOT  = 4,
  parameter int SZ_W   = 3,
  parameter int IP_W   = 32,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [SZ_W-1:0]   acc_size,
  input logic [IP_W-1:0]   acc_next_ip,
  input logic [STAT_W-1:0] status_in,
  input logic [STAT_W-1:0] status_out,
  input logic              status_we,
  input logic [IP_W-1:0]   ip_out,
  input logic              ip_we,
  input logic              dbg_req,
  input logic              io_check_en
);
  // R5
  status_strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> (status_we && ip_we && status_out[NSLOT-1:0] != '0));
  // R5
  status_upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready |=> (status_we |-> status_out[STAT_W-1:NSLOT] == $past(status_in[STAT_W-1:NSLOT])));
  // R6
  ip_from_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready |=> (ip_we |-> ip_out == $past(acc_next_ip)));
  // R8
  trap_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_ready) |=> !dbg_req);
  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_ready) |=> ($stable(status_out) && $stable(ip_out)));
  // R9
  trap_implies_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> io_check_en);
  // R10
  bad_size_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !(acc_size == 1 || acc_size == 2 || acc_size == 4)) |=> !dbg_req);
endmodule

bind iobp_port_trap iobp_port_trap_chk #(
  .NSLOT(NSLOT), .SZ_W(SZ_W), .IP_W(IP_W), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_size(acc_size), .acc_next_ip(acc_next_ip), .status_in(status_in),
  .status_out(status_out), .status_we(status_we), .ip_out(ip_out),
  .ip_we(ip_we), .dbg_req(dbg_req), .io_check_en(io_check_en)
);

// File: tb/test_iobp_port_trap.sv
module test_iobp_port_trap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dbg_ctrl = '0;
  logic [63:0] slot_addr = 64'hFFFE_03F8_0070_0060;
  logic [31:0] status_in = 32'hFFFF_0FF0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [15:0] acc_port = '0;
  logic [2:0]  acc_size = '0;
  logic [31:0] acc_next_ip = '0;
  logic [31:0] status_out, ip_out;
  logic        status_we, ip_we, dbg_req, io_check_en;
  logic [7:0]  dbg_vector;

  int total = 0;
  int bad = 0;
  logic [31:0] prev_status = '0;
  logic [31:0] prev_ip = '0;

  always #10 clk = ~clk;

  iobp_port_trap i_iobp_port_trap (
    .clk(clk), .rst_n(rst_n), .dbg_ctrl(dbg_ctrl), .slot_addr(slot_addr),
    .status_in(status_in), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_port(acc_port), .acc_size(acc_size), .acc_next_ip(acc_next_ip),
    .status_out(status_out), .status_we(status_we), .ip_out(ip_out),
    .ip_we(ip_we), .dbg_req(dbg_req), .dbg_vector(dbg_vector),
    .io_check_en(io_check_en)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [15:0] port;
    logic [2:0]  size;
    logic [3:0]  mask;
    logic        flag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0002_0001, 16'h0060, 3'd1, 4'h1, 1'b1},
    '{32'h0002_0001, 16'h005F, 3'd1, 4'h0, 1'b1},
    '{32'h0002_0001, 16'h005F, 3'd2, 4'h1, 1'b1},
    '{32'h0002_0001, 16'h0061, 3'd1, 4'h0, 1'b1},
    '{32'h00E0_0008, 16'h0073, 3'd4, 4'h2, 1'b1},
    '{32'h00E0_0008, 16'h0074, 3'd1, 4'h0, 1'b1},
    '{32'h00E0_0008, 16'h006D, 3'd4, 4'h2, 1'b1},
    '{32'h0A00_0030, 16'h03FF, 3'd1, 4'h4, 1'b1},
    '{32'h0A00_0030, 16'h0400, 3'd2, 4'h0, 1'b1},
    '{32'h6000_0040, 16'hFFFF, 3'd4, 4'h8, 1'b1},
    '{32'h6000_0040, 16'h0000, 3'd4, 4'h0, 1'b1},
    '{32'h0001_0001, 16'h0060, 3'd1, 4'h0, 1'b0},
    '{32'h0002_0000, 16'h0060, 3'd1, 4'h0, 1'b0},
    '{32'h0002_0002, 16'h0060, 3'd1, 4'h1, 1'b1},
    '{32'h0002_0001, 16'h0060, 3'd3, 4'h0, 1'b1},
    '{32'h6AE2_0079, 16'h0060, 3'd4, 4'h1, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_access(input logic [31:0] ctrl, input logic [15:0] port,
                           input logic [2:0] size, input logic [3:0] mask,
                           input logic flag, input logic [31:0] nip);
    logic [31:0] exp_st, exp_ip;
    @(negedge clk);
    dbg_ctrl = ctrl; acc_port = port; acc_size = size; acc_next_ip = nip;
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    exp_st = (mask != 0) ? {status_in[31:4], mask} : prev_status;
    exp_ip = (mask != 0) ? nip : prev_ip;
    chk("R4 R5 status_out", status_out, exp_st);
    chk("R5 status_we", status_we, mask != 0);
    chk("R6 ip_out", ip_out, exp_ip);
    chk("R6 dbg_req ip_we", {dbg_req, ip_we}, (mask != 0) ? 2'b11 : 2'b00);
    chk("R9 io_check_en", io_check_en, flag);
    prev_status = status_out;
    prev_ip = ip_out;
    @(negedge clk);
    chk("R8 strobes one cycle", {dbg_req, ip_we, status_we}, 3'b000);
    chk("R7 hold status", status_out, prev_status);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs", {acc_ready, status_we, ip_we, dbg_req, io_check_en}, 5'b0);
    chk("R11 reset status", status_out, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", acc_ready, 1'b1);
    chk("R6 vector", dbg_vector, 8'd1);

    // R1 R2 R3 R10 table walk
    for (int k = 0; k < NV; k++)
      do_access(VECS[k].ctrl, VECS[k].port, VECS[k].size, VECS[k].mask,
                VECS[k].flag, 32'h1000_0000 + 32'(k) * 32'h10);

    // R4 multi-hit: slot1 base moved to 0x0061
    slot_addr = 64'hFFFE_03F8_0061_0060;
    do_access(32'h6AE2_0079, 16'h0060, 3'd2, 4'h3, 1'b1, 32'hCAFE_0002);

    // R3 window crossing the top of port space (len 8 at 0xFFF9)
    slot_addr = 64'h0000_0000_0000_FFF9;
    do_access(32'h000A_0001, 16'hFFFF, 3'd1, 4'h1, 1'b1, 32'hCAFE_0010);
    do_access(32'h000A_0001, 16'h0000, 3'd1, 4'h0, 1'b1, 32'hCAFE_0020);

    // R5 upper status bits follow status_in
    status_in = 32'h1234_5670;
    slot_addr = 64'hFFFE_03F8_0070_0060;
    do_access(32'h0002_0001, 16'h0060, 3'd1, 4'h1, 1'b1, 32'hCAFE_0030);

    // R7 R9 idle cycle with ctrl change: flag follows, no strobes
    @(negedge clk);
    dbg_ctrl = 32'h0;
    @(negedge clk);
    chk("R9 flag drops", io_check_en, 1'b0);
    chk("R7 idle no strobe", {dbg_req, ip_we, status_we}, 3'b000);
    chk("R7 idle ip hold", ip_out, prev_ip);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule